// File: doc/BRIEF.md
# Single-Operand Instruction Execution Unit

This unit executes the one-operand instruction class of a 16-bit register-based processor: two right rotates (arithmetic and through carry), a byte swap, a sign extension and three stack operations (push, call and interrupt return). The processor front end hands over the instruction word together with the already-resolved operand value and the current program counter, stack pointer and status register. The unit returns one result item that carries the result value, a register write enable, the destination register number and the next PC, SP and status register.

Instructions enter on a valid/ready stream, and results leave on a second valid/ready stream. An instruction moves across when `ins_valid` and `ins_ready` are both high at a rising edge. A result moves across when `res_valid` and `res_ready` are both high. While the consumer holds `res_ready` low, the result item stays frozen and no new instruction is accepted.

Register-only operations produce their result one cycle after acceptance. Push, call and return walk through a short sequence on one word-wide memory port that uses request and acknowledge. `busy` is high for that whole sequence, and the result item appears in the cycle after the final acknowledge.

Top module: `unop_exec_unit`

## Requirements
- R1: An instruction belongs to the class only when bits 15..10 equal 000100. Bits 9..7 then select the operation: 000 rotate-through-carry, 001 byte swap, 010 rotate-arithmetic, 011 sign extend, 100 push, 101 call, 110 interrupt return. Any other word, and code 111, yields a result equal to the operand with write enable 0 and PC, SP and SR unchanged.
- R2: The status register holds C at bit 0, Z at bit 1, N at bit 2 and V at bit 8. Z is set when the result at the operating width is zero. N is the top bit of that width. The other SR bits pass through unchanged. A register-only operation presents its result in the cycle after acceptance.
- R3: Rotate-arithmetic shifts right by one, keeps the top bit of the width, moves the old bit 0 into C and clears V.
- R4: Rotate-through-carry shifts right by one and puts the old C into the top bit of the width. The old bit 0 goes to C. V is set only when the old C is 1 and the old top bit is 0.
- R5: Bit 6 = 1 selects byte width for the two rotates and for push. At byte width only the low 8 bits take part, N is bit 7, and the upper byte of the result is zero. For the other operations bit 6 is ignored.
- R6: Sign extend copies bit 7 into bits 15..8, clears V and sets C to the inverse of Z.
- R7: Byte swap exchanges the two bytes and leaves the whole SR unchanged.
- R8: Push writes the operand (zero-extended low byte at byte width) to address SP-2 and returns SP-2. PC and SR are unchanged.
- R9: Call writes the incoming PC to address SP-2, returns SP-2 and returns the operand as the new PC. SR is unchanged.
- R10: Interrupt return reads address SP into SR, then reads address SP+2 into PC, and returns SP+4. Both are reads.
- R11: A memory request keeps its address, direction and data until it is acknowledged.
- R12: `ins_ready` is low while `busy` is high or while a result is waiting. A waiting result holds all of its fields until it is taken.
- R13: `res_wr` is 1 only for the four register operations with destination addressing bits 5..4 = 00. `res_dst` is bits 3..0 of the instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ins_valid | input | 1 | Instruction item offered |
| ins_ready | output | 1 | Unit can take an instruction |
| ins_word | input | 16 | Instruction word |
| opnd | input | W | Resolved operand value |
| pc_in | input | W | Current program counter |
| sp_in | input | W | Current stack pointer |
| sr_in | input | W | Current status register |
| res_valid | output | 1 | Result item present |
| res_ready | input | 1 | Consumer takes the result |
| res_data | output | W | Result value |
| res_wr | output | 1 | Write result to destination register |
| res_dst | output | 4 | Destination register number |
| res_pc | output | W | Next program counter |
| res_sp | output | W | Next stack pointer |
| res_sr | output | W | Next status register |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | W | Byte address of the word |
| mem_wdata | output | W | Write data |
| mem_ack | input | 1 | Request completed this cycle |
| mem_rdata | input | W | Read data, valid with ack |
| busy | output | 1 | Stack sequence in progress |

## Verification
Two activities can land in the same cycle: a finished result held under back-pressure, and the next instruction waiting on the input with `ins_valid` high. A pseudo-random pattern drives `res_ready` low for stretches while the driver keeps offering instructions. Stack sequences meet random acknowledge gaps at the same time. Each cycle, the monitor checks that a held item keeps every field and that nothing is accepted before the item drains. The scoreboard then checks that every result and every memory access arrives in order with the values worked out from the requirements.

// File: rtl/unop_pkg.sv
package unop_pkg;
  localparam int IW = 16;

  localparam int C_POS = 0;
  localparam int Z_POS = 1;
  localparam int N_POS = 2;
  localparam int V_POS = 8;

  typedef enum logic [2:0] {
    OP_RRC  = 3'd0,
    OP_SWPB = 3'd1,
    OP_RRA  = 3'd2,
    OP_SXT  = 3'd3,
    OP_PUSH = 3'd4,
    OP_CALL = 3'd5,
    OP_RETI = 3'd6,
    OP_NONE = 3'd7
  } unop_e;

  typedef struct packed {
    unop_e      op;
    logic       byte_md;
    logic       reg_dir;
    logic       alu_wr;
    logic       stack;
    logic [3:0] dst;
  } dec_t;
endpackage

// File: rtl/unop_decode.sv
module unop_decode
  import unop_pkg::*;
(
  input  logic [IW-1:0] ins_word,
  output dec_t          dec
);
  logic  in_group;
  unop_e op;

  always_comb begin
    in_group = (ins_word[15:10] == 6'b000100);
    op       = in_group ? unop_e'(ins_word[9:7]) : OP_NONE;
    dec.op      = op;
    dec.byte_md = ins_word[6] && (op == OP_RRC || op == OP_RRA || op == OP_PUSH);
    dec.reg_dir = (ins_word[5:4] == 2'b00);
    dec.alu_wr  = (op == OP_RRC) || (op == OP_SWPB) || (op == OP_RRA) || (op == OP_SXT);
    dec.stack   = (op == OP_PUSH) || (op == OP_CALL) || (op == OP_RETI);
    dec.dst     = ins_word[3:0];
  end
endmodule

// File: rtl/unop_alu.sv
module unop_alu
  import unop_pkg::*;
#(
  parameter int W = 16
) (
  input  unop_e        op,
  input  logic         byte_md,
  input  logic [W-1:0] opnd,
  input  logic [W-1:0] sr_in,
  output logic [W-1:0] res,
  output logic [W-1:0] sr_out
);
  localparam int HALF = W / 2;

  logic [W-1:0] src;
  logic         top_bit;
  logic         c_old;
  logic         n_new;
  logic         z_new;
  logic         c_new;
  logic         v_new;
  logic         upd;

  always_comb begin
    src     = byte_md ? {{HALF{1'b0}}, opnd[HALF-1:0]} : opnd;
    top_bit = byte_md ? src[HALF-1] : src[W-1];
    c_old   = sr_in[C_POS];
    res     = opnd;
    c_new   = c_old;
    v_new   = sr_in[V_POS];
    upd     = 1'b0;
    unique case (op)
      OP_RRA, OP_RRC: begin
        res = src >> 1;
        if (byte_md) res[HALF-1] = (op == OP_RRA) ? top_bit : c_old;
        else         res[W-1]    = (op == OP_RRA) ? top_bit : c_old;
        c_new = src[0];
        v_new = (op == OP_RRC) ? (c_old & ~top_bit) : 1'b0;
        upd   = 1'b1;
      end
      OP_SWPB: res = {opnd[HALF-1:0], opnd[W-1:HALF]};
      OP_SXT: begin
        res   = {{HALF{opnd[HALF-1]}}, opnd[HALF-1:0]};
        v_new = 1'b0;
        upd   = 1'b1;
      end
      default: res = opnd;
    endcase
    z_new = (res == '0);
    n_new = byte_md ? res[HALF-1] : res[W-1];
    if (op == OP_SXT) c_new = ~z_new;
    sr_out = sr_in;
    if (upd) begin
      sr_out[C_POS] = c_new;
      sr_out[Z_POS] = z_new;
      sr_out[N_POS] = n_new;
      sr_out[V_POS] = v_new;
    end
  end
endmodule

// File: rtl/unop_stack_fsm.sv
module unop_stack_fsm
  import unop_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  unop_e        op,
  input  logic         byte_md,
  input  logic [W-1:0] opnd,
  input  logic [W-1:0] pc_in,
  input  logic [W-1:0] sp_in,
  input  logic [W-1:0] sr_in,
  output logic         mem_req,
  output logic         mem_we,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] mem_wdata,
  input  logic         mem_ack,
  input  logic [W-1:0] mem_rdata,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] fin_pc,
  output logic [W-1:0] fin_sp,
  output logic [W-1:0] fin_sr
);
  localparam int HALF = W / 2;
  localparam logic [W-1:0] STEP = W'(W / 8);

  typedef enum logic [1:0] {S_IDLE, S_WR, S_RD_SR, S_RD_PC} st_e;

  st_e          state;
  logic [W-1:0] addr_q;
  logic [W-1:0] wdata_q;
  logic [W-1:0] pc_q;
  logic [W-1:0] sp_q;
  logic [W-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      pc_q    <= '0;
      sp_q    <= '0;
      sr_q    <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (start) begin
          sr_q <= sr_in;
          pc_q <= pc_in;
          if (op == OP_RETI) begin
            addr_q <= sp_in;
            sp_q   <= sp_in + STEP + STEP;
            state  <= S_RD_SR;
          end else begin
            addr_q  <= sp_in - STEP;
            sp_q    <= sp_in - STEP;
            state   <= S_WR;
            if (op == OP_CALL) begin
              wdata_q <= pc_in;
              pc_q    <= opnd;
            end else begin
              wdata_q <= byte_md ? {{HALF{1'b0}}, opnd[HALF-1:0]} : opnd;
            end
          end
        end
        S_WR: if (mem_ack) state <= S_IDLE;
        S_RD_SR: if (mem_ack) begin
          sr_q   <= mem_rdata;
          addr_q <= addr_q + STEP;
          state  <= S_RD_PC;
        end
        S_RD_PC: if (mem_ack) begin
          pc_q  <= mem_rdata;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req   = (state != S_IDLE);
    mem_we    = (state == S_WR);
    mem_addr  = addr_q;
    mem_wdata = wdata_q;
    busy      = (state != S_IDLE);
    done      = mem_ack && (state == S_WR || state == S_RD_PC);
    fin_pc    = (state == S_RD_PC) ? mem_rdata : pc_q;
    fin_sp    = sp_q;
    fin_sr    = sr_q;
  end

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  // R10
  reti_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && !mem_we && state == S_RD_SR |=> mem_req && !mem_we && mem_addr == $past(mem_addr) + STEP);
endmodule

// File: rtl/unop_exec_unit.sv
module unop_exec_unit
  import unop_pkg::*;
#(
  parameter int W = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ins_valid,
  output logic          ins_ready,
  input  logic [IW-1:0] ins_word,
  input  logic [W-1:0]  opnd,
  input  logic [W-1:0]  pc_in,
  input  logic [W-1:0]  sp_in,
  input  logic [W-1:0]  sr_in,
  output logic          res_valid,
  input  logic          res_ready,
  output logic [W-1:0]  res_data,
  output logic          res_wr,
  output logic [3:0]    res_dst,
  output logic [W-1:0]  res_pc,
  output logic [W-1:0]  res_sp,
  output logic [W-1:0]  res_sr,
  output logic          mem_req,
  output logic          mem_we,
  output logic [W-1:0]  mem_addr,
  output logic [W-1:0]  mem_wdata,
  input  logic          mem_ack,
  input  logic [W-1:0]  mem_rdata,
  output logic          busy
);
  dec_t         dec;
  logic [W-1:0] alu_res;
  logic [W-1:0] alu_sr;
  logic         ins_fire;
  logic         stk_done;
  logic [W-1:0] fin_pc;
  logic [W-1:0] fin_sp;
  logic [W-1:0] fin_sr;

  unop_decode u_dec (
    .ins_word (ins_word),
    .dec      (dec)
  );

  unop_alu #(.W(W)) u_alu (
    .op      (dec.op),
    .byte_md (dec.byte_md),
    .opnd    (opnd),
    .sr_in   (sr_in),
    .res     (alu_res),
    .sr_out  (alu_sr)
  );

  assign ins_ready = !busy && !res_valid;
  assign ins_fire  = ins_valid && ins_ready;

  unop_stack_fsm #(.W(W)) u_stk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (ins_fire && dec.stack),
    .op        (dec.op),
    .byte_md   (dec.byte_md),
    .opnd      (opnd),
    .pc_in     (pc_in),
    .sp_in     (sp_in),
    .sr_in     (sr_in),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .mem_rdata (mem_rdata),
    .busy      (busy),
    .done      (stk_done),
    .fin_pc    (fin_pc),
    .fin_sp    (fin_sp),
    .fin_sr    (fin_sr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
      res_wr    <= 1'b0;
      res_dst   <= '0;
      res_pc    <= '0;
      res_sp    <= '0;
      res_sr    <= '0;
    end else if (ins_fire) begin
      res_dst <= dec.dst;
      if (dec.stack) begin
        res_data <= opnd;
        res_wr   <= 1'b0;
      end else begin
        res_valid <= 1'b1;
        res_data  <= alu_res;
        res_wr    <= dec.alu_wr && dec.reg_dir;
        res_pc    <= pc_in;
        res_sp    <= sp_in;
        res_sr    <= alu_sr;
      end
    end else if (stk_done) begin
      res_valid <= 1'b1;
      res_pc    <= fin_pc;
      res_sp    <= fin_sp;
      res_sr    <= fin_sr;
    end else if (res_valid && res_ready) begin
      res_valid <= 1'b0;
    end
  end

  // R12
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_data) && $stable(res_sr)
      && $stable(res_pc) && $stable(res_sp) && $stable(res_wr));

  // R12
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ins_ready);

  // R2
  alu_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ins_fire && !dec.stack |=> res_valid && !busy);
endmodule

// File: tb/sim_unop_exec_unit.sv
module sim_unop_exec_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ins_valid = 1'b0;
  logic        ins_ready;
  logic [15:0] ins_word = '0;
  logic [15:0] opnd = '0, pc_in = '0, sp_in = '0, sr_in = '0;
  logic        res_valid;
  logic        res_ready;
  logic [15:0] res_data, res_pc, res_sp, res_sr;
  logic        res_wr;
  logic [3:0]  res_dst;
  logic        mem_req, mem_we, mem_ack;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic        busy;

  logic [15:0] lfsr = 16'hACE1;
  logic [15:0] bmem [0:15];
  int n_chk = 0;
  int n_bad = 0;

  typedef struct {
    logic [15:0] d, pc, sp, sr;
    logic        wr;
    logic [3:0]  dst;
    string       tag;
  } exp_t;
  typedef struct {
    logic        we;
    logic [15:0] addr, data;
    string       tag;
  } mexp_t;
  exp_t  sb[$];
  mexp_t mq[$];

  always #5 clk = ~clk;

  assign res_ready = rst_n && (lfsr[5] | lfsr[9]);
  assign mem_ack   = mem_req && (lfsr[2] | lfsr[11]);
  assign mem_rdata = bmem[mem_addr[4:1]];

  unop_exec_unit u0 (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_ready(ins_ready),
    .ins_word(ins_word), .opnd(opnd), .pc_in(pc_in), .sp_in(sp_in), .sr_in(sr_in),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data), .res_wr(res_wr),
    .res_dst(res_dst), .res_pc(res_pc), .res_sp(res_sp), .res_sr(res_sr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .busy(busy)
  );

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  function automatic logic [15:0] setf(logic [15:0] sr, logic c, logic z, logic n, logic v);
    logic [15:0] s = sr;
    s[0] = c; s[1] = z; s[2] = n; s[8] = v;
    return s;
  endfunction

  task automatic model(logic [15:0] ins, logic [15:0] a, logic [15:0] pc,
                       logic [15:0] sp, logic [15:0] sr, string tag);
    exp_t e;
    mexp_t m;
    logic [2:0] op = ins[9:7];
    logic bw = ins[6];
    logic [7:0] b;
    logic msb;
    e.d = a; e.pc = pc; e.sp = sp; e.sr = sr; e.wr = 1'b0; e.dst = ins[3:0]; e.tag = tag;
    if (ins[15:10] == 6'b000100 && op != 3'd7) begin
      case (op)
        3'd0, 3'd2: begin
          if (bw) begin
            b = a[7:0];
            msb = b[7];
            e.d = {8'h00, (op == 3'd2) ? msb : sr[0], b[7:1]};
            e.sr = setf(sr, b[0], e.d == 0, e.d[7], (op == 3'd0) && sr[0] && !msb);
          end else begin
            msb = a[15];
            e.d = {(op == 3'd2) ? msb : sr[0], a[15:1]};
            e.sr = setf(sr, a[0], e.d == 0, e.d[15], (op == 3'd0) && sr[0] && !msb);
          end
          e.wr = (ins[5:4] == 2'b00);
        end
        3'd1: begin
          e.d = {a[7:0], a[15:8]};
          e.wr = (ins[5:4] == 2'b00);
        end
        3'd3: begin
          e.d = {{8{a[7]}}, a[7:0]};
          e.sr = setf(sr, e.d != 0, e.d == 0, e.d[15], 1'b0);
          e.wr = (ins[5:4] == 2'b00);
        end
        3'd4: begin
          e.sp = sp - 2;
          m.we = 1'b1; m.addr = sp - 2; m.data = bw ? {8'h00, a[7:0]} : a; m.tag = tag;
          mq.push_back(m);
        end
        3'd5: begin
          e.sp = sp - 2; e.pc = a;
          m.we = 1'b1; m.addr = sp - 2; m.data = pc; m.tag = tag;
          mq.push_back(m);
        end
        default: begin
          e.sr = bmem[sp[4:1]];
          e.pc = bmem[sp[4:1] + 4'd1];
          e.sp = sp + 4;
          m.we = 1'b0; m.addr = sp; m.data = '0; m.tag = tag;
          mq.push_back(m);
          m.addr = sp + 2;
          mq.push_back(m);
        end
      endcase
    end
    sb.push_back(e);
  endtask

  task automatic send(logic [15:0] ins, logic [15:0] a, logic [15:0] pc,
                      logic [15:0] sp, logic [15:0] sr, string tag);
    ins_word = ins; opnd = a; pc_in = pc; sp_in = sp; sr_in = sr;
    ins_valid = 1'b1;
    do @(negedge clk); while (!ins_ready);
    model(ins, a, pc, sp, sr, tag);
    @(posedge clk); #1;
    ins_valid = 1'b0;
  endtask

  function automatic logic [15:0] enc(int op, int bw, int ad, int rg);
    return 16'h1000 | 16'(op << 7) | 16'(bw << 6) | 16'(ad << 4) | 16'(rg);
  endfunction

  // pseudo-random back-pressure and acknowledge gaps
  initial forever begin
    @(posedge clk); #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  end

  // monitor / scoreboard
  initial begin
    exp_t  e;
    mexp_t m;
    logic held = 1'b0;
    logic [15:0] h_d, h_sr, h_pc, h_sp;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (held && res_valid) begin
          chk("R12 held data", res_data, h_d);
          chk("R12 held sr", res_sr, h_sr);
          chk("R12 held pc/sp", {res_pc ^ res_sp}, {h_pc ^ h_sp});
        end
        held = res_valid && !res_ready;
        h_d = res_data; h_sr = res_sr; h_pc = res_pc; h_sp = res_sp;
        if (busy || res_valid) begin
          n_chk++;
          if (ins_ready) begin
            n_bad++;
            $display("FAIL R12 ins_ready: actual 1 expected 0");
          end
        end
        if (res_valid && res_ready) begin
          if (sb.size() == 0) begin
            n_chk++; n_bad++;
            $display("FAIL R12 unexpected result: actual %h expected none", res_data);
          end else begin
            e = sb.pop_front();
            chk({e.tag, " data"}, res_data, e.d);
            chk({e.tag, " R13 wr"}, {15'd0, res_wr}, {15'd0, e.wr});
            chk({e.tag, " R13 dst"}, {12'd0, res_dst}, {12'd0, e.dst});
            chk({e.tag, " pc"}, res_pc, e.pc);
            chk({e.tag, " sp"}, res_sp, e.sp);
            chk({e.tag, " sr"}, res_sr, e.sr);
          end
        end
        if (mem_req && mem_ack) begin
          if (mq.size() == 0) begin
            n_chk++; n_bad++;
            $display("FAIL R11 unexpected access: actual %h expected none", mem_addr);
          end else begin
            m = mq.pop_front();
            chk({m.tag, " R11 we"}, {15'd0, mem_we}, {15'd0, m.we});
            chk({m.tag, " R11 addr"}, mem_addr, m.addr);
            if (m.we) chk({m.tag, " wdata"}, mem_wdata, m.data);
          end
          if (mem_we) bmem[mem_addr[4:1]] = mem_wdata;
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R12 watchdog: actual hung expected done");
    summary();
  end

  initial begin
    for (int i = 0; i < 16; i++) bmem[i] = 16'(i * 16'h0101);
    bmem[4] = 16'h0105;
    bmem[5] = 16'h6000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R12 reset res_valid", {15'd0, res_valid}, 16'd0);
    chk("R11 reset mem_req", {15'd0, mem_req}, 16'd0);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R12 reset ins_ready", {15'd0, ins_ready}, 16'd1);
    chk("R12 reset busy", {15'd0, busy}, 16'd0);
    @(posedge clk); #1;

    send(enc(2, 0, 0, 5), 16'h8001, 16'h4400, 16'h0020, 16'h0000, "R3 rra word");
    send(enc(2, 0, 0, 6), 16'h0001, 16'h4400, 16'h0020, 16'h0100, "R3 R2 rra zero");
    send(enc(2, 1, 0, 7), 16'h12F0, 16'h4400, 16'h0020, 16'h0000, "R5 rra byte");
    send(enc(0, 0, 0, 4), 16'h0001, 16'h4400, 16'h0020, 16'h0001, "R4 rrc word");
    send(enc(0, 1, 0, 4), 16'hAB03, 16'h4400, 16'h0020, 16'h0000, "R4 R5 rrc byte");
    send(enc(0, 0, 0, 9), 16'h8000, 16'h4400, 16'h0020, 16'h0001, "R4 rrc no v");
    send(enc(1, 1, 0, 3), 16'h1234, 16'h4400, 16'h0020, 16'h0107, "R7 swpb");
    send(enc(3, 0, 0, 8), 16'h0080, 16'h4400, 16'h0020, 16'h0100, "R6 sxt neg");
    send(enc(3, 0, 0, 8), 16'hFF00, 16'h4400, 16'h0020, 16'h0005, "R6 sxt zero");
    send(enc(4, 0, 0, 1), 16'hBEEF, 16'h4400, 16'h0010, 16'h0003, "R8 push word");
    send(enc(4, 1, 0, 1), 16'h12AB, 16'h4400, 16'h000E, 16'h0000, "R8 R5 push byte");
    send(enc(5, 0, 0, 2), 16'h5000, 16'h4400, 16'h0010, 16'h0002, "R9 call");
    send(enc(6, 0, 0, 0), 16'h0000, 16'h4400, 16'h0008, 16'h0000, "R10 reti");
    send(16'h4005, 16'h7777, 16'h4400, 16'h0020, 16'h0003, "R1 not in class");
    send(enc(7, 0, 0, 5), 16'h7777, 16'h4400, 16'h0020, 16'h0003, "R1 code 111");
    send(16'h1100 | 16'h0C00, 16'h7777, 16'h4400, 16'h0020, 16'h0003, "R1 bits 11..10");
    send(enc(2, 0, 1, 5), 16'h0004, 16'h4400, 16'h0020, 16'h0000, "R13 indirect no wr");
    send(enc(3, 0, 3, 5), 16'h007F, 16'h4400, 16'h0020, 16'h0000, "R13 sxt mode 11");
    for (int k = 0; k < 6; k++) begin
      send(enc(k % 4, k % 2, 0, k), 16'(16'h9A31 * (k + 1)), 16'h4400, 16'h0020,
           16'(k), "R2 mix");
      send(enc(4, 0, 0, 1), 16'(k), 16'h4400, 16'h0018, 16'h0000, "R11 R12 push burst");
    end

    while (sb.size() != 0 || mq.size() != 0 || res_valid) @(negedge clk);
    repeat (4) @(negedge clk);
    summary();
  end
endmodule